// File: doc/BRIEF.md
# Framed Serial Result Transmitter

This block sends every conversion result as a 16-bit serial frame that starts as soon as a conversion is requested. It makes three open-drain lines: a serial clock at half the converter clock rate, an active-low frame strobe, and a serial data line. Each line is shown as a pull-low enable and the level that the line settles to. A released line reads high.

A frame begins when the active-low start strobe falls. The strobe line goes low within a few converter-clock cycles of that edge and stays low until the frame ends. The frame is four zero bits followed by the 12-bit result, most significant bit first. Data moves on rising serial-clock edges and is sampled by the receiver on falling edges.

A mode input selects the clock behaviour. In free-running mode the serial clock toggles all the time, which suits receivers that need a continuous clock. In gated mode the clock is released high between frames, so several transmitters can share one set of lines.

Top module: `sar_frame_tx`

## Requirements
- R1: A frame carries 16 bits. The first four are 0, then result bits 11 down to 0. The result is taken on the clock edge where the strobe falls.
- R2: The data line changes only on rising serial-clock edges. Its level never changes on a falling edge.
- R3: The strobe line stays low for the whole frame. It goes high on the rising edge that follows the 16th falling edge. While the strobe is high the data line is released (reads 1).
- R4: After the first clock edge that samples the start input low (where the previous sample was high), the strobe goes low within that edge or the next one. This is always within three converter-clock cycles.
- R5: The first falling serial-clock edge comes exactly one converter clock after the strobe falls. The data line holds the first leading zero at that edge.
- R6: The serial clock toggles on every converter-clock edge. With `free_run`=1 it keeps toggling between frames.
- R7: With `free_run`=0 the serial clock is released (reads 1) while no frame is active.
- R8: A start falling edge that arrives during an active frame is ignored. It does not change the frame in progress and does not cause a later frame.
- R9: Every output pair is open-drain: a pull of 1 gives a level of 0, and a pull of 0 gives 1. After reset all three lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n | input | 1 | Active-low start-conversion strobe; a frame starts on its falling edge |
| free_run | input | 1 | 1: serial clock runs continuously; 0: serial clock is stopped between frames |
| result | input | 12 | Conversion result to transmit |
| sck_pull | output | 1 | Pull-low enable for the serial clock line |
| sck_o | output | 1 | Resolved serial clock level |
| fs_pull | output | 1 | Pull-low enable for the frame strobe line |
| fs_o | output | 1 | Resolved frame strobe level (low during a frame) |
| sd_pull | output | 1 | Pull-low enable for the serial data line |
| sd_o | output | 1 | Resolved serial data level |

## Verification
The assertions assume the following about the inputs:
- `start_n` is synchronous to `clk`.
- `result` is held steady from the start pulse until the strobe falls.
- `free_run` changes only between frames. The gated-idle check uses the mode value from the previous cycle.

The stimulus drives every input on the falling clock edge. It holds `result` and `free_run` fixed across each frame. The only exception is the ignored-start scenario, which changes `result` on purpose during a frame. Start pulses last one cycle, and the bench applies them at both serial-clock phases in free-running mode.

// File: rtl/sar_frame_tx.sv
`timescale 1ns/1ps
module sar_frame_tx #(
  parameter int DATA_W = 12,
  parameter int LEAD_W = 4,
  localparam int FRAME_W = DATA_W + LEAD_W,
  localparam int CNT_W = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic              free_run,
  input  logic [DATA_W-1:0] result,
  output logic              sck_pull,
  output logic              sck_o,
  output logic              fs_pull,
  output logic              fs_o,
  output logic              sd_pull,
  output logic              sd_o
);

  logic               start_q;
  logic               pend;
  logic               active;
  logic               sck_r;
  logic [CNT_W-1:0]   bitcnt;
  logic [FRAME_W-1:0] shreg;

  wire fall_det = start_q & ~start_n;
  wire go       = pend | fall_det;
  wire idle_sck = free_run ? ~sck_r : 1'b1;
  wire begin_f  = ~active & go & idle_sck;
  wire last_bit = bitcnt == CNT_W'(FRAME_W - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      pend    <= 1'b0;
      active  <= 1'b0;
      sck_r   <= 1'b1;
      bitcnt  <= '0;
      shreg   <= '0;
    end else begin
      start_q <= start_n;
      if (active) begin
        sck_r <= ~sck_r;
        if (!sck_r) begin
          shreg  <= shreg << 1;
          bitcnt <= bitcnt + 1'b1;
          if (last_bit) active <= 1'b0;
        end
      end else begin
        sck_r <= idle_sck;
        if (begin_f) begin
          active <= 1'b1;
          pend   <= 1'b0;
          shreg  <= {{LEAD_W{1'b0}}, result};
          bitcnt <= '0;
        end else if (fall_det) begin
          pend <= 1'b1;
        end
      end
    end
  end

  assign sck_pull = ~sck_r;
  assign sck_o    = ~sck_pull;
  assign fs_pull  = active;
  assign fs_o     = ~fs_pull;
  assign sd_pull  = active & ~shreg[FRAME_W-1];
  assign sd_o     = ~sd_pull;

  logic [CNT_W:0] fall_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                fall_cnt <= '0;
    else if (begin_f)          fall_cnt <= '0;
    else if (active && sck_r)  fall_cnt <= fall_cnt + 1'b1;
  end

  // R2
  sd_stable_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_o) |-> $stable(sd_o));

  // R3
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_o) |-> fall_cnt == (CNT_W+1)'(FRAME_W));

  // R4
  strobe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !pend && !fs_o);

  // R7
  gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && $past(!free_run) && fs_o && $past(fs_o)) |-> sck_o);

  // R9
  released_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_o |-> (sd_o && !sd_pull));

endmodule

// File: tb/sar_frame_tx_bench.sv
`timescale 1ns/1ps
module sar_frame_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1;
  logic free_run = 1'b0;
  logic [11:0] result = '0;
  logic sck_pull, sck_o, fs_pull, fs_o, sd_pull, sd_o;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sar_frame_tx u_sar_frame_tx (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .free_run(free_run),
    .result(result), .sck_pull(sck_pull), .sck_o(sck_o), .fs_pull(fs_pull),
    .fs_o(fs_o), .sd_pull(sd_pull), .sd_o(sd_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [11:0] val, input bit fr, input int skew,
                            input int inject_at, input logic [11:0] inj_val,
                            output logic [15:0] got, output int falls,
                            output int lat, output int first_fall,
                            output int bad_stable, output int bad_od);
    bit psck, psd;
    int n;
    @(negedge clk);
    free_run = fr;
    result = val;
    repeat (skew) @(negedge clk);
    start_n = 1'b0;
    lat = 1;
    @(negedge clk);
    start_n = 1'b1;
    while (fs_o && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    got = '0; falls = 0; first_fall = -1; bad_stable = 0; bad_od = 0; n = 0;
    psck = sck_o; psd = sd_o;
    while (!fs_o && n < 100) begin
      @(negedge clk);
      n++;
      if (start_n == 1'b0) start_n = 1'b1;
      if (sd_o != !sd_pull || sck_o != !sck_pull || fs_o != !fs_pull) bad_od++;
      if (psck && !sck_o) begin
        falls++;
        if (first_fall < 0) first_fall = n;
        got = {got[14:0], sd_o};
        if (sd_o != psd) bad_stable++;
      end
      if (n == inject_at) begin
        start_n = 1'b0;
        result = inj_val;
      end
      psck = sck_o; psd = sd_o;
    end
    start_n = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(sck_o && fs_o && sd_o, "R9", {sck_o, fs_o, sd_o}, 3'b111);
    chk(!sck_pull && !fs_pull && !sd_pull, "R9", {sck_pull, fs_pull, sd_pull}, 0);
  endtask

  task automatic t_gated(input logic [11:0] v);
    logic [15:0] got; int falls, lat, ff, bs, bo;
    send_frame(v, 1'b0, 0, -1, '0, got, falls, lat, ff, bs, bo);
    chk(got == {4'b0, v}, "R1", got, {4'b0, v});
    chk(falls == 16, "R3", falls, 16);
    chk(lat >= 1 && lat <= 3, "R4", lat, 1);
    chk(ff == 1 && got[15] == 1'b0, "R5", ff, 1);
    chk(bs == 0, "R2", bs, 0);
    chk(bo == 0, "R9", bo, 0);
    @(negedge clk);
    chk(sd_o && fs_o, "R3", {sd_o, fs_o}, 2'b11);
  endtask

  task automatic t_free(input logic [11:0] v, input int skew);
    logic [15:0] got; int falls, lat, ff, bs, bo; int toggles;
    bit p;
    send_frame(v, 1'b1, skew, -1, '0, got, falls, lat, ff, bs, bo);
    chk(got == {4'b0, v}, "R1", got, {4'b0, v});
    chk(falls == 16, "R3", falls, 16);
    chk(lat >= 1 && lat <= 3, "R4", lat, 2);
    chk(ff == 1, "R5", ff, 1);
    chk(bs == 0, "R2", bs, 0);
    toggles = 0;
    p = sck_o;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sck_o != p) toggles++;
      p = sck_o;
    end
    chk(toggles == 10, "R6", toggles, 10);
  endtask

  task automatic t_gated_idle;
    int high_cnt;
    @(negedge clk);
    free_run = 1'b0;
    repeat (2) @(negedge clk);
    high_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sck_o && !sck_pull) high_cnt++;
    end
    chk(high_cnt == 20, "R7", high_cnt, 20);
  endtask

  task automatic t_ignore;
    logic [15:0] got; int falls, lat, ff, bs, bo; int extra;
    send_frame(12'h123, 1'b0, 0, 9, 12'hEDC, got, falls, lat, ff, bs, bo);
    chk(got == 16'h0123, "R8", got, 16'h0123);
    chk(falls == 16, "R8", falls, 16);
    extra = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!fs_o) extra++;
    end
    chk(extra == 0, "R8", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gated(12'hA5C);
    t_gated(12'hFFF);
    t_gated(12'h000);
    t_free(12'h3F1, 0);
    t_free(12'h8C7, 1);
    t_gated_idle();
    t_ignore();
    t_gated(12'h801);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule